// File: doc/BRIEF.md
# LIN Transmit Guard and Fault Reporter

This block sits between a LIN controller and the bus driver of a LIN transceiver. It keeps the node from holding the bus dominant for ever. It also checks that what the node transmits actually appears on the bus. It passes the controller's transmit data to the driver only while no disabling condition is active. Otherwise it forces the driver data recessive and clears the driver enable.

Two dominant-length watchdogs guard the driver, and each one re-enables the driver in its own way. The transmit watchdog counts how long the transmit input stays low. The bus watchdog counts how long the received bus level stays low. A loop check takes one sample of the received level a fixed settling delay after each transmit falling edge, and holds that result until the next sample.

A thermal-overload level and an external low on the shared fault/enable line also disable the driver. Faults are merged into one level for the mode controller and into an open-drain pull-down request for the fault/enable line. A per-cause sticky status vector is cleared whenever the driver is re-enabled. Timer lengths are set in microseconds against a clock frequency in kHz.

Top module: `lin_txguard`

## Requirements
- R1: When `tx_req` is sampled low on TXTO consecutive rising edges (TXTO = CLK_KHZ*TXTO_US/1000), the outputs change after the TXTO-th edge. From then on `drv_en` is 0, `drv_tx` is 1 and `fault_lvl` is 1.
- R2: A transmit-timeout fault persists while `tx_req` stays low, whatever the bus does. It clears at the first edge that samples `tx_req` high.
- R3: When `bus_rx` is sampled low on BDOM consecutive edges (BDOM = CLK_KHZ*BDOM_US/1000), the driver is disabled and `fault_lvl` rises. A single recessive sample restarts the count.
- R4: After a bus-dominant disable, the driver is re-enabled at the first edge that samples `bus_rx` high together with `chip_sel` high. While `chip_sel` is low it stays disabled.
- R5: A falling edge of `tx_req` is seen while the driver is enabled. CMP edges after it (CMP = CLK_KHZ*CMP_US/1000), `bus_rx` is sampled if `tx_req` is still low. A high sample sets the short fault, which raises `fault_lvl` but leaves the driver enabled. A low sample clears it.
- R6: The short-fault result is held between samples: bus or transmit changes after a sample do not alter it.
- R7: `therm_ovl` high clears `drv_en` and raises `fault_lvl` and `fen_pull` in the same cycle, without any edge. When it falls, the driver recovers by itself if no other cause is active.
- R8: `txe_ext_n` low disables the driver and forces `drv_tx` to 1, but raises neither `fault_lvl` nor `fen_pull`. No loop-check sample is started while the driver is disabled.
- R9: `fen_pull` (a request to pull the active-low fault/enable line low) equals `fault_lvl`. That is the OR of the timeout, bus-dominant, short and thermal causes.
- R10: Sticky status `flt_stat` uses bit 0 for timeout, bit 1 for bus-dominant, bit 2 for short and bit 3 for thermal. A bit is set one edge after its cause is seen. The vector is cleared at the edge after `drv_en` rises.
- R11: After reset `drv_en`=1, `drv_tx` follows a high `tx_req`, and `fault_lvl`, `fen_pull` and `flt_stat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Transmit data from the controller (0 = dominant) |
| bus_rx | input | 1 | Received bus level (0 = dominant) |
| chip_sel | input | 1 | Chip select; gates bus-dominant recovery |
| therm_ovl | input | 1 | Thermal overload level |
| txe_ext_n | input | 1 | Level seen from external drive of the fault/enable line |
| drv_tx | output | 1 | Data to the bus driver, recessive when disabled |
| drv_en | output | 1 | Bus driver enable |
| fault_lvl | output | 1 | Combined fault level to the mode controller |
| fen_pull | output | 1 | Pull fault/enable line low |
| flt_stat | output | 4 | Sticky fault causes |

## Verification
The transmit timeout and a thermal overload can disable the driver on the same edge. The bench raises the thermal input just before the edge on which the timeout expires. It then releases the thermal input while transmit data is still low. The driver must stay off, held by the timeout alone, with both status bits set. Only a high transmit sample may bring the driver back, and the status must clear one edge later.

// File: rtl/lin_guard_pkg.sv
package lin_guard_pkg;

  typedef struct packed {
    logic therm;
    logic shrt;
    logic bdom;
    logic txto;
  } cause_t;

  localparam int NCAUSE = 4;

  function automatic int cnt_w(input int n);
    int w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

  function automatic int us_to_cyc(input int khz, input int us);
    int c;
    c = (khz * us) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/lin_dom_timer.sv
module lin_dom_timer #(
  parameter int LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_low,
  input  logic clr_ok,
  output logic expired
);
  localparam int CW = lin_guard_pkg::cnt_w(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          flg_q, flg_d;

  always_comb begin
    cnt_en = lvl_low ? (cnt_q != LAST) : (cnt_q != '0);
    cnt_d  = lvl_low ? cnt_q + 1'b1 : '0;
    flg_d  = flg_q;
    if (lvl_low && (cnt_q == LAST)) flg_d = 1'b1;
    else if (!lvl_low && clr_ok)    flg_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flg_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      flg_q <= flg_d;
    end
  end

  assign expired = flg_q;

  // R1, R3: the flag only rises after a low sample
  a_r3_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q) |-> $past(lvl_low));
  // R2, R4: the flag only falls after a high sample with recovery allowed
  a_r4_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flg_q) |-> $past(!lvl_low && clr_ok));
endmodule

// File: rtl/lin_loop_check.sv
module lin_loop_check #(
  parameter int DELAY = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic bus_rx,
  input  logic tx_en,
  output logic short_flt
);
  localparam int CW = lin_guard_pkg::cnt_w(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic          txp_q;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          shrt_q, shrt_d;
  logic          fall, smp;

  always_comb begin
    fall   = tx_en && !tx_req && txp_q;
    smp    = pend_q && (cnt_q == LAST) && tx_en && !tx_req;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    shrt_d = shrt_q;
    if (fall) begin
      pend_d = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (pend_q) begin
      if (tx_req || !tx_en) begin
        pend_d = 1'b0;
      end else if (smp) begin
        pend_d = 1'b0;
        shrt_d = bus_rx;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txp_q  <= 1'b1;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      shrt_q <= 1'b0;
    end else begin
      txp_q  <= tx_req;
      pend_q <= pend_d;
      if (cnt_en) cnt_q <= cnt_d;
      shrt_q <= shrt_d;
    end
  end

  assign short_flt = shrt_q;

  // R5: a short is only reported after a recessive sample while transmitting low
  a_r5_short_from_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shrt_q) |-> $past(bus_rx && !tx_req));
  // R6: without a pending sample the result holds
  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(shrt_q));
endmodule

// File: rtl/lin_fault_stat.sv
module lin_fault_stat (
  input  logic                 clk,
  input  logic                 rst_n,
  input  lin_guard_pkg::cause_t cause,
  input  logic                 reen,
  output logic [lin_guard_pkg::NCAUSE-1:0] stat
);
  localparam int N = lin_guard_pkg::NCAUSE;

  logic [N-1:0] cv;
  assign cv = cause;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      logic st_q, st_d, st_en;
      always_comb begin
        st_en = reen || cv[gi];
        st_d  = cv[gi];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st_q <= 1'b0;
        else if (st_en) st_q <= st_d;
      end
      assign stat[gi] = st_q;
    end
  endgenerate
endmodule

// File: rtl/lin_txguard.sv
module lin_txguard #(
  parameter int CLK_KHZ  = 1000,
  parameter int TXTO_US  = 10000,
  parameter int BDOM_US  = 25000,
  parameter int CMP_US   = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_req,
  input  logic       bus_rx,
  input  logic       chip_sel,
  input  logic       therm_ovl,
  input  logic       txe_ext_n,
  output logic       drv_tx,
  output logic       drv_en,
  output logic       fault_lvl,
  output logic       fen_pull,
  output logic [3:0] flt_stat
);
  import lin_guard_pkg::*;

  localparam int TXTO_CYC = us_to_cyc(CLK_KHZ, TXTO_US);
  localparam int BDOM_CYC = us_to_cyc(CLK_KHZ, BDOM_US);
  localparam int CMP_CYC  = us_to_cyc(CLK_KHZ, CMP_US);

  logic   to_flt, bd_flt, sh_flt;
  logic   blk, en_q, reen;
  cause_t cause;

  lin_dom_timer #(.LIMIT(TXTO_CYC)) u_txto (
    .clk(clk), .rst_n(rst_n), .lvl_low(!tx_req), .clr_ok(1'b1),
    .expired(to_flt));

  lin_dom_timer #(.LIMIT(BDOM_CYC)) u_bdom (
    .clk(clk), .rst_n(rst_n), .lvl_low(!bus_rx), .clr_ok(chip_sel),
    .expired(bd_flt));

  lin_loop_check #(.DELAY(CMP_CYC)) u_loop (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .bus_rx(bus_rx),
    .tx_en(drv_en), .short_flt(sh_flt));

  always_comb begin
    blk         = to_flt || bd_flt || therm_ovl || !txe_ext_n;
    cause.txto  = to_flt;
    cause.bdom  = bd_flt;
    cause.shrt  = sh_flt;
    cause.therm = therm_ovl;
    reen        = !blk && !en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= !blk;
  end

  lin_fault_stat u_stat (
    .clk(clk), .rst_n(rst_n), .cause(cause), .reen(reen), .stat(flt_stat));

  assign drv_en    = !blk;
  assign drv_tx    = tx_req || blk;
  assign fault_lvl = |cause;
  assign fen_pull  = fault_lvl;

  // R7: overload always silences the driver and flags the line
  a_r7_therm_off: assert property (@(posedge clk) disable iff (!rst_n)
    therm_ovl |-> (!drv_en && fen_pull));
  // R4: with chip select low the bus-dominant disable persists
  a_r4_hold_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_flt && !chip_sel) |=> bd_flt);
  // R10: status is empty one edge after the driver comes back
  a_r10_clear_on_reen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |=> (flt_stat[1:0] == 2'b00));
endmodule

// File: tb/lin_txguard_test.sv
module lin_txguard_test;
  localparam int CLK_P = 10;
  localparam int TXTO = 40;
  localparam int BDOM = 100;
  localparam int CMP  = 5;

  logic clk, rst_n, tx_req, chip_sel, therm_ovl, txe_ext_n;
  logic bus_ovr, bus_val, bus_rx;
  logic drv_tx, drv_en, fault_lvl, fen_pull;
  logic [3:0] flt_stat;
  int n_run, n_fail;

  assign bus_rx = bus_ovr ? bus_val : drv_tx;

  lin_txguard #(.CLK_KHZ(1000), .TXTO_US(TXTO), .BDOM_US(BDOM), .CMP_US(CMP)) uut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .bus_rx(bus_rx),
    .chip_sel(chip_sel), .therm_ovl(therm_ovl), .txe_ext_n(txe_ext_n),
    .drv_tx(drv_tx), .drv_en(drv_en), .fault_lvl(fault_lvl),
    .fen_pull(fen_pull), .flt_stat(flt_stat));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 drv_en", drv_en, 1);
    chk("R11 drv_tx", drv_tx, 1);
    chk("R11 fault", {fault_lvl, fen_pull}, 0);
    chk("R11 stat", flt_stat, 0);
  endtask

  task automatic t_txto;
    tx_req = 0;
    tick(TXTO - 1);
    chk("R1 before limit", {drv_en, drv_tx, fault_lvl}, 3'b100);
    tick(1);
    chk("R1 expired", {drv_en, drv_tx, fault_lvl}, 3'b011);
    chk("R9 pull", fen_pull, 1);
    tick(1);
    chk("R10 txto bit", flt_stat, 4'b0001);
    bus_ovr = 1; bus_val = 1;
    tick(5);
    chk("R2 held low", drv_en, 0);
    bus_ovr = 0;
    tx_req = 1;
    tick(1);
    chk("R2 released", {drv_en, fault_lvl}, 2'b10);
    tick(1);
    chk("R10 cleared", flt_stat, 0);
  endtask

  task automatic t_bdom;
    bus_ovr = 1; bus_val = 0;
    tick(60);
    bus_val = 1;
    tick(1);
    bus_val = 0;
    tick(BDOM - 1);
    chk("R3 restart", drv_en, 1);
    tick(1);
    chk("R3 expired", {drv_en, fault_lvl}, 2'b01);
    chip_sel = 0; bus_val = 1;
    tick(3);
    chk("R4 cs low hold", drv_en, 0);
    chk("R10 bdom bit", flt_stat, 4'b0010);
    chip_sel = 1;
    tick(1);
    chk("R4 recover", {drv_en, fault_lvl}, 2'b10);
    bus_ovr = 0;
    tick(2);
  endtask

  task automatic t_therm;
    therm_ovl = 1;
    #1;
    chk("R7 immediate", {drv_en, fault_lvl, fen_pull}, 3'b011);
    tick(2);
    chk("R10 therm bit", flt_stat, 4'b1000);
    therm_ovl = 0;
    #1;
    chk("R7 recover", {drv_en, fault_lvl}, 2'b10);
    tick(2);
    chk("R10 therm clear", flt_stat, 0);
  endtask

  task automatic t_ext;
    txe_ext_n = 0; tx_req = 0;
    tick(10);
    chk("R8 disabled", {drv_en, drv_tx}, 2'b01);
    chk("R8 no fault", {fault_lvl, fen_pull}, 0);
    tx_req = 1; txe_ext_n = 1;
    tick(CMP + 2);
    chk("R8 no sample", {drv_en, fault_lvl}, 2'b10);
  endtask

  task automatic t_overlap;
    tx_req = 0;
    tick(TXTO - 1);
    therm_ovl = 1;
    tick(1);
    therm_ovl = 0;
    #1;
    chk("R1 after overlap", {drv_en, fault_lvl}, 2'b01);
    tick(1);
    chk("R10 overlap bits", flt_stat, 4'b1001);
    tx_req = 1;
    tick(1);
    chk("R2 overlap release", drv_en, 1);
    tick(1);
    chk("R10 overlap clear", flt_stat, 0);
  endtask

  task automatic t_short;
    bus_ovr = 1; bus_val = 1;
    tx_req = 0;
    tick(CMP);
    chk("R5 before sample", fault_lvl, 0);
    tick(1);
    chk("R5 short", {fault_lvl, fen_pull, drv_en}, 3'b111);
    tick(1);
    chk("R10 short bit", flt_stat[2], 1);
    tx_req = 1;
    tick(3);
    chk("R6 held", fault_lvl, 1);
    bus_ovr = 0;
    tx_req = 0;
    tick(CMP + 1);
    chk("R5 cleared", fault_lvl, 0);
    bus_ovr = 1; bus_val = 1;
    tick(2);
    chk("R6 held clear", fault_lvl, 0);
    tx_req = 1; bus_ovr = 0;
    tick(2);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 0; tx_req = 1; chip_sel = 1; therm_ovl = 0; txe_ext_n = 1;
    bus_ovr = 0; bus_val = 1;
    tick(3);
    rst_n = 1;
    tick(2);
    t_reset();
    t_txto();
    t_bdom();
    t_therm();
    t_ext();
    t_overlap();
    t_short();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule